// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit operands over several clock cycles. It works through one slice of the multiplier operand per iteration, taking 8 bits at a time by default and starting from the least significant end. The multiplicand is always used at full width. Before the first iteration the block looks at the multiplier operand and finds the point above which every bit is a copy of the fill bit. It then runs only as many iterations as are needed to reach that point. Small multipliers therefore finish early.

The final slice is widened by the fill bit, so the result is still the exact two's-complement or unsigned product. The block can also add a supplied accumulator value. It returns either the low 32 bits of the product or the full 64-bit product.

A caller pulses `start_i` with the operands and the mode bits. It then waits for the one-cycle `done_o`. The result and the iteration count stay on the outputs until the next operation is accepted. While an operation is in progress, further start pulses are ignored.

The controller has five states:
- IDLE: waiting for a start pulse.
- ITER: one slice per cycle.
- ACCUM: the accumulator is added.
- UPPER: the upper result word is loaded.
- DONE: the one-cycle completion state.

The transitions are:
- IDLE→ITER on start.
- ITER→ITER while slices remain.
- ITER→ACCUM, ITER→UPPER or ITER→DONE after the last slice, in that order of preference, depending on the mode.
- ACCUM→UPPER in long mode, otherwise ACCUM→DONE.
- UPPER→DONE.
- DONE→IDLE.

Top module: `etmul_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o` and `iter_o` are all zero.
- R2: The fill bit is `op_b_i[31]` when `signed_i` is 1 or `long_i` is 0. The iteration count M is the smallest k in 1..4 for which `op_b_i` bits [31:8k] all equal the fill bit. For k=4 this range is empty, so M is 4 when no smaller k matches. Bits below 8k do not affect the test.
- R3: In unsigned long mode (`signed_i`=0, `long_i`=1), the fill bit is 0. Early termination then needs the upper bits to be all zero, so for example 0xFFFFFFFF gives M=4.
- R4: With `long_i`=0, `result_o[31:0]` is the low 32 bits of `op_a_i`×`op_b_i` and `result_o[63:32]` is zero.
- R5: With `long_i`=1, `result_o` is the full 64-bit product. It is signed×signed when `signed_i`=1 and unsigned×unsigned otherwise.
- R6: With `accum_i`=1, the product is added to `acc_i` before it is returned. Long mode uses all 64 bits of `acc_i`; short mode uses only `acc_i[31:0]`, modulo 2^32.
- R7: `busy_o` is high for exactly 1+M cycles, plus one more in long mode and one more with accumulate. The last of these cycles is the one in which `done_o` is high.
- R8: `done_o` is high for exactly one cycle per operation, and `busy_o` is low in the following cycle.
- R9: After `done_o`, `result_o` and `iter_o` hold their values until the next accepted start. `iter_o` shows M from the moment the operation is accepted.
- R10: A start pulse while `busy_o` is high is ignored. The running operation's result, iteration count and timing are unchanged.
- R11: With the slice-width parameter set to 12, there are three slices. The count follows the same rule over bits [31:12k]: 1 for k=1, 2 for k=2, and 3 for all remaining values. The products stay exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; operands and mode are captured when accepted |
| signed_i | input | 1 | 1 = two's-complement operands |
| long_i | input | 1 | 1 = 64-bit result |
| accum_i | input | 1 | 1 = add `acc_i` to the product |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier, scanned slice by slice |
| acc_i | input | 64 | Accumulator addend |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| iter_o | output | 3 | Iteration count M of the current or last operation |
| result_o | output | 64 | Product or accumulated product |

## Verification
The multiplier operand is driven with values that sit on either side of each 8-bit boundary: the largest value that still ends after k slices and the smallest that needs k+1. Each of these is tried positive and negative, and in every combination of signed, long and accumulate modes. This separates a count taken from the wrong bit range, or one that uses the sign rule where the zero rule applies, from a correct one. Random operands, with magnitudes scaled so that every count occurs often, check that the early stop still gives exact products, because an incorrectly widened final slice shows up as a wrong upper word. Start pulses issued mid-operation, and a second instance built with 12-bit slices, cover the ignore rule and the alternative slice width.

// File: rtl/etmul_pkg.sv
package etmul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ITER,
        ST_ACCUM,
        ST_UPPER,
        ST_DONE
    } etmul_state_e;

endpackage

// File: rtl/etmul_term_detect.sv
// Finds how many multiplier slices are needed: the smallest k such that
// every bit at or above k*SLICE of the padded operand equals the fill bit.
module etmul_term_detect #(
    parameter int WIDTH = 32,
    parameter int SLICE = 8
) (
    input  logic [WIDTH-1:0]                              rs_i,
    input  logic                                          ext_i,
    output logic                                          fill_o,
    output logic [((WIDTH+SLICE-1)/SLICE)*SLICE-1:0]      rs_pad_o,
    output logic [$clog2((WIDTH+SLICE-1)/SLICE+1)-1:0]    m_o
);
    localparam int NS    = (WIDTH + SLICE - 1) / SLICE;
    localparam int PADW  = NS * SLICE;
    localparam int CNT_W = $clog2(NS + 1);

    logic          fill;
    logic [NS:1]   hit;

    assign fill   = ext_i & rs_i[WIDTH-1];
    assign fill_o = fill;

    generate
        if (PADW > WIDTH) begin : g_pad
            assign rs_pad_o = {{(PADW-WIDTH){fill}}, rs_i};
        end else begin : g_nopad
            assign rs_pad_o = rs_i;
        end
    endgenerate

    generate
        for (genvar k = 1; k < NS; k++) begin : g_hit
            assign hit[k] = (rs_pad_o[PADW-1:k*SLICE] == {(PADW-k*SLICE){fill}});
        end
    endgenerate
    assign hit[NS] = 1'b1;

    // first matching range wins
    always_comb begin
        m_o = CNT_W'(NS);
        for (int k = NS - 1; k >= 1; k--) begin
            if (hit[k]) m_o = CNT_W'(k);
        end
    end

endmodule

// File: rtl/etmul_slice_pp.sv
// One iteration's partial product: full multiplicand times one widened slice,
// aligned to the slice position.
module etmul_slice_pp #(
    parameter int WIDTH = 32,
    parameter int SLICE = 8
) (
    input  logic [WIDTH:0]                                a_ext_i,
    input  logic [((WIDTH+SLICE-1)/SLICE)*SLICE-1:0]      rs_pad_i,
    input  logic [$clog2((WIDTH+SLICE-1)/SLICE+1)-1:0]    idx_i,
    input  logic                                          last_i,
    input  logic                                          fill_i,
    output logic [2*WIDTH-1:0]                            pp_o
);
    localparam int PW = WIDTH + SLICE + 2;
    localparam int RW = 2 * WIDTH;

    logic [SLICE-1:0]  slice_bits;
    logic [SLICE:0]    slice_ext;
    logic [PW-1:0]     a_wide;
    logic [PW-1:0]     m_wide;
    logic [PW-1:0]     prod;
    logic [RW-1:0]     prod_ext;
    int                base;

    always_comb begin
        base       = int'(idx_i) * SLICE;
        slice_bits = rs_pad_i[base +: SLICE];
        // the final slice carries the fill bit as its sign, which folds the
        // discarded upper bits back into the product
        slice_ext  = {last_i & fill_i, slice_bits};
        a_wide     = {{(PW-WIDTH-1){a_ext_i[WIDTH]}}, a_ext_i};
        m_wide     = {{(PW-SLICE-1){slice_ext[SLICE]}}, slice_ext};
        prod       = a_wide * m_wide;
        prod_ext   = {{(RW-PW){prod[PW-1]}}, prod};
        pp_o       = prod_ext << base;
    end

endmodule

// File: rtl/etmul_ctrl.sv
module etmul_ctrl
    import etmul_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] m_i,
    input  logic             long_i,
    input  logic             accum_i,
    output logic             accept_o,
    output logic             iter_en_o,
    output logic             last_o,
    output logic             accum_en_o,
    output logic             upper_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] idx_o
);
    etmul_state_e     state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             last_slice;

    assign last_slice = (idx_q == m_i - CNT_W'(1));

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ITER;
                    idx_d   = '0;
                end
            end
            ST_ITER: begin
                idx_d = idx_q + CNT_W'(1);
                if (last_slice) begin
                    if (accum_i)     state_d = ST_ACCUM;
                    else if (long_i) state_d = ST_UPPER;
                    else             state_d = ST_DONE;
                end
            end
            ST_ACCUM: state_d = long_i ? ST_UPPER : ST_DONE;
            ST_UPPER: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o   = (state_q == ST_IDLE) && start_i;
        iter_en_o  = (state_q == ST_ITER);
        last_o     = (state_q == ST_ITER) && last_slice;
        accum_en_o = (state_q == ST_ACCUM);
        upper_en_o = (state_q == ST_UPPER);
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        idx_o      = idx_q;
    end

endmodule

// File: rtl/etmul_top.sv
module etmul_top #(
    parameter int WIDTH = 32,
    parameter int SLICE = 8
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        start_i,
    input  logic                                        signed_i,
    input  logic                                        long_i,
    input  logic                                        accum_i,
    input  logic [WIDTH-1:0]                            op_a_i,
    input  logic [WIDTH-1:0]                            op_b_i,
    input  logic [2*WIDTH-1:0]                          acc_i,
    output logic                                        busy_o,
    output logic                                        done_o,
    output logic [$clog2((WIDTH+SLICE-1)/SLICE+1)-1:0]  iter_o,
    output logic [2*WIDTH-1:0]                          result_o
);
    localparam int NS    = (WIDTH + SLICE - 1) / SLICE;
    localparam int PADW  = NS * SLICE;
    localparam int CNT_W = $clog2(NS + 1);
    localparam int RW    = 2 * WIDTH;

    logic             ext;
    logic             fill_w;
    logic [PADW-1:0]  rs_pad_w;
    logic [CNT_W-1:0] m_w;

    logic [WIDTH:0]   a_ext_q;
    logic [PADW-1:0]  rs_pad_q;
    logic             fill_q;
    logic [CNT_W-1:0] m_q;
    logic             long_q;
    logic             accum_q;
    logic [RW-1:0]    addend_q;
    logic [RW-1:0]    sum_q;
    logic [WIDTH-1:0] hi_q;

    logic             accept, iter_en, last, accum_en, upper_en;
    logic [CNT_W-1:0] idx;
    logic [RW-1:0]    pp;

    // short results only need the low word, so the sign rule is safe there
    assign ext = signed_i | ~long_i;

    etmul_term_detect #(.WIDTH(WIDTH), .SLICE(SLICE)) u_detect (
        .rs_i     (op_b_i),
        .ext_i    (ext),
        .fill_o   (fill_w),
        .rs_pad_o (rs_pad_w),
        .m_o      (m_w)
    );

    etmul_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .m_i        (m_q),
        .long_i     (long_q),
        .accum_i    (accum_q),
        .accept_o   (accept),
        .iter_en_o  (iter_en),
        .last_o     (last),
        .accum_en_o (accum_en),
        .upper_en_o (upper_en),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .idx_o      (idx)
    );

    etmul_slice_pp #(.WIDTH(WIDTH), .SLICE(SLICE)) u_pp (
        .a_ext_i  (a_ext_q),
        .rs_pad_i (rs_pad_q),
        .idx_i    (idx),
        .last_i   (last),
        .fill_i   (fill_q),
        .pp_o     (pp)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_ext_q  <= '0;
            rs_pad_q <= '0;
            fill_q   <= 1'b0;
            m_q      <= '0;
            long_q   <= 1'b0;
            accum_q  <= 1'b0;
            addend_q <= '0;
            sum_q    <= '0;
            hi_q     <= '0;
        end else if (accept) begin
            a_ext_q  <= {ext & op_a_i[WIDTH-1], op_a_i};
            rs_pad_q <= rs_pad_w;
            fill_q   <= fill_w;
            m_q      <= m_w;
            long_q   <= long_i;
            accum_q  <= accum_i;
            addend_q <= long_i ? acc_i : {{WIDTH{1'b0}}, acc_i[WIDTH-1:0]};
            sum_q    <= '0;
            hi_q     <= '0;
        end else if (iter_en) begin
            sum_q    <= sum_q + pp;
        end else if (accum_en) begin
            sum_q    <= sum_q + addend_q;
        end else if (upper_en) begin
            hi_q     <= sum_q[RW-1:WIDTH];
        end
    end

    assign iter_o   = m_q;
    assign result_o = {hi_q, sum_q[WIDTH-1:0]};

endmodule

// File: rtl/etmul_checker.sv
module etmul_checker #(
    parameter int WIDTH = 32,
    parameter int SLICE = 8
) (
    input logic                                        clk_i,
    input logic                                        rst_ni,
    input logic                                        start_i,
    input logic                                        busy_o,
    input logic                                        done_o,
    input logic [$clog2((WIDTH+SLICE-1)/SLICE+1)-1:0]  iter_o,
    input logic [2*WIDTH-1:0]                          result_o
);
    localparam int NS    = (WIDTH + SLICE - 1) / SLICE;
    localparam int CNT_W = $clog2(NS + 1);

    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);

    a_r2_iter_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (iter_o >= CNT_W'(1) && iter_o <= CNT_W'(NS)));

    a_r7_start_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (busy_o && !done_o));

    a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> (busy_o && $stable(iter_o)));

    a_r9_hold_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> ($stable(result_o) && $stable(iter_o)));

    a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(iter_o)));

endmodule

bind etmul_top etmul_checker #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .iter_o   (iter_o),
    .result_o (result_o)
);

// File: tb/etmul_top_tb_top.sv
`timescale 1ns/1ps
module etmul_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0, lng = 1'b0, acc_en = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [63:0] acc = '0;
    logic        sel12 = 1'b0;

    logic        busy8, done8, busy12, done12;
    logic [2:0]  iter8;
    logic [1:0]  iter12;
    logic [63:0] res8, res12;

    logic        busy, done;
    logic [2:0]  iter;
    logic [63:0] res;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    etmul_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start & ~sel12),
        .signed_i(sgn), .long_i(lng), .accum_i(acc_en),
        .op_a_i(op_a), .op_b_i(op_b), .acc_i(acc),
        .busy_o(busy8), .done_o(done8), .iter_o(iter8), .result_o(res8)
    );

    etmul_top #(.SLICE(12)) dut12_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start & sel12),
        .signed_i(sgn), .long_i(lng), .accum_i(acc_en),
        .op_a_i(op_a), .op_b_i(op_b), .acc_i(acc),
        .busy_o(busy12), .done_o(done12), .iter_o(iter12), .result_o(res12)
    );

    assign busy = sel12 ? busy12 : busy8;
    assign done = sel12 ? done12 : done8;
    assign iter = sel12 ? {1'b0, iter12} : iter8;
    assign res  = sel12 ? res12 : res8;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_m(input logic [31:0] b, input bit s, input bit l, input int sw);
        int  ns = (32 + sw - 1) / sw;
        bit  fill = (s || !l) ? b[31] : 1'b0;
        for (int k = 1; k <= ns; k++) begin
            bit ok = 1'b1;
            for (int i = k * sw; i < ns * sw; i++) begin
                bit v = (i < 32) ? b[i] : fill;
                if (v != fill) ok = 1'b0;
            end
            if (ok) return k;
        end
        return ns;
    endfunction

    function automatic logic [63:0] exp_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic [63:0] ac, input bit s, input bit l, input bit ae);
        logic [63:0] p;
        if (l && !s) p = {32'b0, a} * {32'b0, b};
        else         p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        if (ae) p = p + (l ? ac : {32'b0, ac[31:0]});
        if (!l) p = {32'b0, p[31:0]};
        return p;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [63:0] ac,
                          input bit s, input bit l, input bit ae, input bit use12, input bit poke);
        int          cycles = 0;
        int          em;
        int          ecyc;
        logic [63:0] er;
        logic [63:0] got;
        logic [2:0]  got_m;
        bit          seen = 1'b0;
        em   = exp_m(b, s, l, use12 ? 12 : 8);
        er   = exp_res(a, b, ac, s, l, ae);
        ecyc = 1 + em + (l ? 1 : 0) + (ae ? 1 : 0);
        @(negedge clk);
        sel12 = use12;
        op_a = a; op_b = b; acc = ac; sgn = s; lng = l; acc_en = ae;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cycles < 64) begin
            if (busy) cycles++;
            if (done) begin
                seen = 1'b1;
                break;
            end
            if (poke && cycles == 1) begin
                start = 1'b1;   // R10: must be ignored
                op_a = ~a; op_b = ~b; acc = ~ac; sgn = ~s; lng = ~l; acc_en = ~ae;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        got   = res;
        got_m = iter;
        chk(seen, "R8 done seen", {63'b0, seen}, 64'd1);
        chk(cycles == ecyc, use12 ? "R11 busy cycles" : (poke ? "R10 busy cycles" : "R7 busy cycles"),
            64'(cycles), 64'(ecyc));
        chk(got_m == 3'(em), use12 ? "R11 iteration count" : (l && !s ? "R3 iteration count" : "R2 iteration count"),
            64'(got_m), 64'(em));
        chk(got == er, use12 ? "R11 result" : (poke ? "R10 result" : (ae ? "R6 result" : (l ? "R5 result" : "R4 result"))),
            got, er);
        @(negedge clk);
        chk(!done && !busy, "R8 single done pulse", {62'b0, done, busy}, 64'd0);
        chk(res == got && iter == got_m, "R9 result held", res, got);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] edges [0:15];
        void'($urandom(32'd20240611));
        edges[0]  = 32'h0000_0000; edges[1]  = 32'h0000_00FF;
        edges[2]  = 32'h0000_0100; edges[3]  = 32'h0000_FFFF;
        edges[4]  = 32'h0001_0000; edges[5]  = 32'h00FF_FFFF;
        edges[6]  = 32'h0100_0000; edges[7]  = 32'h7FFF_FFFF;
        edges[8]  = 32'hFFFF_FFFF; edges[9]  = 32'hFFFF_FF00;
        edges[10] = 32'hFFFF_FEFF; edges[11] = 32'hFFFF_0000;
        edges[12] = 32'hFFFE_FFFF; edges[13] = 32'hFF00_0000;
        edges[14] = 32'hFEFF_FFFF; edges[15] = 32'h8000_0000;

        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(busy8 == 1'b0 && done8 == 1'b0, "R1 flags in reset", {62'b0, busy8, done8}, 64'd0);
        chk(res8 == 64'd0 && iter8 == 3'd0, "R1 result in reset", res8, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy8 == 1'b0 && res8 == 64'd0, "R1 after release", res8, 64'd0);

        // directed boundaries, all modes
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 8; m++) begin
                run_op(32'hDEAD_BEEF ^ 32'(i * 977), edges[i], 64'h0123_4567_89AB_CDEF,
                       m[0], m[1], m[2], 1'b0, 1'b0);
            end
        end
        // extreme multiplicands
        run_op(32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 64'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R10: start pulses while busy
        for (int i = 0; i < 16; i++) begin
            run_op($urandom, edges[i], {$urandom, $urandom}, i[0], i[1], i[2], 1'b0, 1'b1);
        end

        // random operands with spread magnitudes
        for (int i = 0; i < 300; i++) begin
            logic [31:0] b = $urandom >> ($urandom % 32);
            if ($urandom % 2) b = ~b;
            run_op($urandom, b, {$urandom, $urandom}, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0);
        end

        // R11: 12-bit slice variant
        run_op(32'h1234_5678, 32'h0000_0FFF, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(32'h1234_5678, 32'h0000_1000, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(32'h1234_5678, 32'h00FF_FFFF, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(32'h1234_5678, 32'h0100_0000, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(32'h9234_5678, 32'hFFFF_F000, 64'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_op(32'h9234_5678, 32'hFFFF_F000, 64'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 60; i++) begin
            logic [31:0] b = $urandom >> ($urandom % 32);
            if ($urandom % 2) b = ~b;
            run_op($urandom, b, {$urandom, $urandom}, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule